// File: doc/BRIEF.md
# Indirect Ethernet Controller Register Port

This block is the host-facing register file of a bus-mastering Ethernet controller. The host reaches it through two 16-bit words. Word 1 is a pointer that picks a register number. Word 0 reads or writes the register that the pointer selects. Reads have no side effects, and the read data is a combinational view of the current state. Every access completes in the cycle it is presented, so the port has no back-pressure and no handshake.

The main register (number 0) holds both control and status. Its commands are load (fetch the initialization block), run, halt and transmit poll. Its event causes are cleared by writing a one to them. It also holds an interrupt enable and two summary bits that hardware computes. The register port turns each command into a one-cycle pulse for the DMA core. It records events that the DMA core reports, and it raises an interrupt line. The other registers hold the initialization-block address (numbers 1 and 2), the bus configuration (3), four receive filter words (8 to 11) and a mode word (15). These drive the rest of the controller as plain outputs.

Top module: `enet_regport`

## Requirements
- R1: After reset, register 0 reads 0x0004 (only the halt bit, bit 2, is set), the pointer is 0, and `irq`, `tx_enable`, `rx_enable` and all command pulses are 0.
- R2: A write to word 1 loads the pointer with the register number. Reading word 1 returns the pointer, zero-extended. Word 0 accesses the selected register. A register number that is not implemented reads 0 and ignores writes.
- R3: A write to register 0 with bit 2 set makes register 0 read exactly 0x0004 and clears every other bit, including causes, the interrupt enable and the active flags. It also gives a one-cycle `cmd_halt` pulse in the cycle after the write.
- R4: A write to register 0 with bit 0 set and bit 2 clear sets bit 0, clears bit 2 and gives a one-cycle `cmd_load` pulse. A later `ev_load_done` sets bit 8.
- R5: A write with bit 1 set (bit 2 clear) sets bit 1 and gives a one-cycle `cmd_run` pulse. Bits 4 and 5 (and `tx_enable`/`rx_enable`) become 1 one cycle after bit 1 and the recorded load completion are both set. Writes to bits 4 and 5 have no effect. Bits 0 and 1 are set-only; writing 0 to them has no effect.
- R6: The cause bits are bit 8 load done, bit 9 transmit done, bit 10 receive done, bit 11 memory error, bit 12 lost frame, bit 13 collision check and bit 14 jabber. Writing 1 to a cause bit clears it; writing 0 leaves it. An event that arrives in the same cycle as a clear of its bit leaves the bit set.
- R7: While bit 2 is set, event inputs are ignored and register 0 does not change unless it is written.
- R8: Bit 15 reads as the OR of bits 14, 13, 12 and 11. Bit 7 reads as the OR of bits 14, 12, 11, 10, 9 and 8. Writes to bits 7 and 15 have no effect.
- R9: Bit 6 is the interrupt enable and holds the value last written to it. `irq` equals bit 7 AND bit 6.
- R10: A write with bit 3 set while bit 2 reads 0 gives a one-cycle `cmd_poll` pulse. Bit 3 always reads 0. While halted, bit 3 is ignored.
- R11: Register 1 holds address bits 15:0 and register 2 holds bits 23:16 in its low 8 bits (its upper bits read 0). Register 3 holds bit 0 byte control, bit 1 address-latch mode and bit 2 byte swap (upper bits read 0). These three registers accept writes only while bit 2 of register 0 is set; at other times the writes are ignored.
- R12: Filter registers 8 to 11 and mode register 15 are read/write at all times. Filter register 8+i drives `filter_bits[16*i+15:16*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | Write when 1, read when 0 |
| host_word | input | 1 | 0 selects the data word, 1 selects the pointer word |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read value of the word chosen by host_word |
| ev_load_done | input | 1 | DMA core finished reading the initialization block |
| ev_tx_done | input | 1 | Transmit descriptor completed |
| ev_rx_done | input | 1 | Receive descriptor completed |
| ev_mem_err | input | 1 | Memory access timeout |
| ev_rx_lost | input | 1 | Frame lost for lack of buffer |
| ev_col_chk | input | 1 | Collision check failure |
| ev_jabber | input | 1 | Transmitter ran too long |
| cmd_load | output | 1 | One-cycle load command |
| cmd_run | output | 1 | One-cycle run command |
| cmd_halt | output | 1 | One-cycle halt command |
| cmd_poll | output | 1 | One-cycle transmit poll command |
| tx_enable | output | 1 | Transmitter active |
| rx_enable | output | 1 | Receiver active |
| irq | output | 1 | Interrupt request |
| init_addr | output | 24 | Initialization-block address |
| bus_cfg | output | 3 | Bus configuration bits |
| filter_bits | output | 64 | Receive filter words |
| mode_word | output | 16 | Mode register |

## Verification
The bench sweeps all 128 cause patterns. For each pattern it checks both summary bits and the interrupt line, then clears the bits with a varied one-to-clear mask. A design that mixed the two summary bit lists, cleared bits on a written zero, or gated the interrupt with the wrong bit would fail there. The bench also fires an event in the same cycle as its clear, which catches a design that loses events when software clears the bit. It writes load and halt together, which catches a design where load wins or leaves causes behind. It writes the address registers while running, and pulses events while halted, to catch a design whose locks leak.

// File: rtl/enet_regport_pkg.sv
package enet_regport_pkg;
  localparam int unsigned WORD_W = 16;

  localparam int unsigned B_LOAD   = 0;
  localparam int unsigned B_RUN    = 1;
  localparam int unsigned B_HALT   = 2;
  localparam int unsigned B_POLL   = 3;
  localparam int unsigned B_TXACT  = 4;
  localparam int unsigned B_RXACT  = 5;
  localparam int unsigned B_IEN    = 6;
  localparam int unsigned B_IRQSUM = 7;
  localparam int unsigned CAUSE_LO = 8;
  localparam int unsigned N_CAUSE  = 7;
  localparam int unsigned B_ERRSUM = 15;

  localparam int unsigned REG_MAIN   = 0;
  localparam int unsigned REG_IBA_LO = 1;
  localparam int unsigned REG_IBA_HI = 2;
  localparam int unsigned REG_BUSCFG = 3;
  localparam int unsigned REG_FILT0  = 8;
  localparam int unsigned REG_MODE   = 15;

  localparam int unsigned BUSCFG_W = 3;

  // cause vector, LSB maps to register bit 8
  typedef struct packed {
    logic jabber;
    logic colchk;
    logic rxlost;
    logic memerr;
    logic rxdone;
    logic txdone;
    logic loaded;
  } cause_t;

  typedef struct packed {
    logic load;
    logic run;
    logic halt;
    logic poll;
  } cmd_t;
endpackage

// File: rtl/enet_regport_decode.sv
module enet_regport_decode
  import enet_regport_pkg::*;
#(
  parameter int unsigned PTR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_en,
  input  logic              host_we,
  input  logic              host_word,
  input  logic [PTR_W-1:0]  ptr_wdata,
  input  logic [WORD_W-1:0] main_rd,
  input  logic [WORD_W-1:0] cfg_rd,
  output logic [PTR_W-1:0]  ptr,
  output logic              wr_main,
  output logic              wr_cfg,
  output logic [WORD_W-1:0] host_rdata
);
  localparam logic [PTR_W-1:0] MAIN_NUM = PTR_W'(REG_MAIN);

  logic [PTR_W-1:0] ptr_q;
  logic             wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (host_en && host_we && host_word) begin
      ptr_q <= ptr_wdata;
    end
  end

  assign wr_data = host_en && host_we && !host_word;
  assign wr_main = wr_data && (ptr_q == MAIN_NUM);
  assign wr_cfg  = wr_data && (ptr_q != MAIN_NUM);
  assign ptr     = ptr_q;

  always_comb begin
    if (host_word) begin
      host_rdata = WORD_W'(ptr_q);
    end else if (ptr_q == MAIN_NUM) begin
      host_rdata = main_rd;
    end else begin
      host_rdata = cfg_rd;
    end
  end
endmodule

// File: rtl/enet_regport_main.sv
module enet_regport_main
  import enet_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  input  cause_t            ev,
  output logic [WORD_W-1:0] rd_val,
  output logic              irq,
  output cmd_t              cmd,
  output logic              act
);
  logic   load_q, run_q, halt_q, ien_q, loadcmp_q, act_q;
  cause_t cause_q, cause_nxt, clr_vec, set_vec;
  cmd_t   cmd_q;
  logic   err_sum, irq_sum;
  logic   wdata_unused;

  assign wdata_unused = ^{wdata[B_ERRSUM], wdata[B_IRQSUM], wdata[B_RXACT], wdata[B_TXACT]};

  always_comb begin
    clr_vec   = wr ? cause_t'(wdata[CAUSE_LO +: N_CAUSE]) : '0;
    set_vec   = halt_q ? '0 : ev;
    cause_nxt = (cause_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q    <= 1'b0;
      run_q     <= 1'b0;
      halt_q    <= 1'b1;
      ien_q     <= 1'b0;
      loadcmp_q <= 1'b0;
      act_q     <= 1'b0;
      cause_q   <= '0;
      cmd_q     <= '0;
    end else begin
      cmd_q <= '0;
      if (wr && wdata[B_HALT]) begin
        // halt dominates every other bit of the same write
        halt_q     <= 1'b1;
        load_q     <= 1'b0;
        run_q      <= 1'b0;
        ien_q      <= 1'b0;
        loadcmp_q  <= 1'b0;
        act_q      <= 1'b0;
        cause_q    <= '0;
        cmd_q.halt <= 1'b1;
      end else begin
        if (wr) begin
          ien_q <= wdata[B_IEN];
          if (wdata[B_LOAD]) begin
            load_q     <= 1'b1;
            halt_q     <= 1'b0;
            loadcmp_q  <= 1'b0;
            cmd_q.load <= 1'b1;
          end
          if (wdata[B_RUN]) begin
            run_q     <= 1'b1;
            halt_q    <= 1'b0;
            cmd_q.run <= 1'b1;
          end
          if (wdata[B_POLL] && !halt_q) begin
            cmd_q.poll <= 1'b1;
          end
        end
        if (ev.loaded && !halt_q) begin
          loadcmp_q <= 1'b1;
        end
        cause_q <= cause_nxt;
        act_q   <= run_q && loadcmp_q;
      end
    end
  end

  assign err_sum = cause_q.jabber | cause_q.colchk | cause_q.rxlost | cause_q.memerr;
  assign irq_sum = cause_q.jabber | cause_q.rxlost | cause_q.memerr |
                   cause_q.rxdone | cause_q.txdone | cause_q.loaded;

  always_comb begin
    rd_val                         = '0;
    rd_val[B_LOAD]                 = load_q;
    rd_val[B_RUN]                  = run_q;
    rd_val[B_HALT]                 = halt_q;
    rd_val[B_TXACT]                = act_q;
    rd_val[B_RXACT]                = act_q;
    rd_val[B_IEN]                  = ien_q;
    rd_val[B_IRQSUM]               = irq_sum;
    rd_val[CAUSE_LO +: N_CAUSE]    = cause_q;
    rd_val[B_ERRSUM]               = err_sum;
  end

  assign irq = irq_sum && ien_q;
  assign cmd = cmd_q;
  assign act = act_q;
endmodule

// File: rtl/enet_regport_cfg.sv
module enet_regport_cfg
  import enet_regport_pkg::*;
#(
  parameter int unsigned PTR_W      = 4,
  parameter int unsigned FILT_WORDS = 4,
  parameter int unsigned AHI_W      = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr,
  input  logic [PTR_W-1:0]             sel,
  input  logic [WORD_W-1:0]            wdata,
  input  logic                         halted,
  output logic [WORD_W+AHI_W-1:0]      init_addr,
  output logic [BUSCFG_W-1:0]          bus_cfg,
  output logic [WORD_W*FILT_WORDS-1:0] filt,
  output logic [WORD_W-1:0]            mode,
  output logic [WORD_W-1:0]            rd_val
);
  localparam logic [PTR_W-1:0] N_LO   = PTR_W'(REG_IBA_LO);
  localparam logic [PTR_W-1:0] N_HI   = PTR_W'(REG_IBA_HI);
  localparam logic [PTR_W-1:0] N_BUS  = PTR_W'(REG_BUSCFG);
  localparam logic [PTR_W-1:0] N_MODE = PTR_W'(REG_MODE);

  logic [WORD_W-1:0]   lo_q;
  logic [AHI_W-1:0]    hi_q;
  logic [BUSCFG_W-1:0] bus_q;
  logic [WORD_W-1:0]   mode_q;
  logic [WORD_W-1:0]   filt_rd [FILT_WORDS];
  logic                wr_locked;

  assign wr_locked = wr && halted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      bus_q <= '0;
    end else if (wr_locked) begin
      if (sel == N_LO)  lo_q  <= wdata;
      if (sel == N_HI)  hi_q  <= wdata[AHI_W-1:0];
      if (sel == N_BUS) bus_q <= wdata[BUSCFG_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (wr && sel == N_MODE) begin
      mode_q <= wdata;
    end
  end

  for (genvar g = 0; g < FILT_WORDS; g++) begin : g_filt
    localparam logic [PTR_W-1:0] MY_NUM = PTR_W'(REG_FILT0 + g);
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (wr && sel == MY_NUM) begin
        word_q <= wdata;
      end
    end
    assign filt[g*WORD_W +: WORD_W] = word_q;
    assign filt_rd[g] = (sel == MY_NUM) ? word_q : '0;
  end

  always_comb begin
    rd_val = '0;
    if (sel == N_LO)   rd_val = lo_q;
    if (sel == N_HI)   rd_val = WORD_W'(hi_q);
    if (sel == N_BUS)  rd_val = WORD_W'(bus_q);
    if (sel == N_MODE) rd_val = mode_q;
    for (int i = 0; i < FILT_WORDS; i++) begin
      rd_val = rd_val | filt_rd[i];
    end
  end

  assign init_addr = {hi_q, lo_q};
  assign bus_cfg   = bus_q;
  assign mode      = mode_q;
endmodule

// File: rtl/enet_regport.sv
module enet_regport
  import enet_regport_pkg::*;
#(
  parameter int unsigned PTR_W      = 4,
  parameter int unsigned FILT_WORDS = 4,
  parameter int unsigned AHI_W      = 8,
  localparam int unsigned IBA_W     = WORD_W + AHI_W,
  localparam int unsigned FILT_W    = WORD_W * FILT_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_en,
  input  logic              host_we,
  input  logic              host_word,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  input  logic              ev_load_done,
  input  logic              ev_tx_done,
  input  logic              ev_rx_done,
  input  logic              ev_mem_err,
  input  logic              ev_rx_lost,
  input  logic              ev_col_chk,
  input  logic              ev_jabber,
  output logic              cmd_load,
  output logic              cmd_run,
  output logic              cmd_halt,
  output logic              cmd_poll,
  output logic              tx_enable,
  output logic              rx_enable,
  output logic              irq,
  output logic [IBA_W-1:0]  init_addr,
  output logic [BUSCFG_W-1:0] bus_cfg,
  output logic [FILT_W-1:0] filter_bits,
  output logic [WORD_W-1:0] mode_word
);
  logic [PTR_W-1:0]  ptr_q;
  logic              wr_main, wr_cfg;
  logic [WORD_W-1:0] main_rd, cfg_rd;
  cause_t            ev_vec;
  cmd_t              cmd;
  logic              act;

  assign ev_vec = '{jabber: ev_jabber, colchk: ev_col_chk, rxlost: ev_rx_lost,
                    memerr: ev_mem_err, rxdone: ev_rx_done, txdone: ev_tx_done,
                    loaded: ev_load_done};

  enet_regport_decode #(.PTR_W(PTR_W)) u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_en    (host_en),
    .host_we    (host_we),
    .host_word  (host_word),
    .ptr_wdata  (host_wdata[PTR_W-1:0]),
    .main_rd    (main_rd),
    .cfg_rd     (cfg_rd),
    .ptr        (ptr_q),
    .wr_main    (wr_main),
    .wr_cfg     (wr_cfg),
    .host_rdata (host_rdata)
  );

  enet_regport_main u_main (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (wr_main),
    .wdata  (host_wdata),
    .ev     (ev_vec),
    .rd_val (main_rd),
    .irq    (irq),
    .cmd    (cmd),
    .act    (act)
  );

  enet_regport_cfg #(
    .PTR_W      (PTR_W),
    .FILT_WORDS (FILT_WORDS),
    .AHI_W      (AHI_W)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (wr_cfg),
    .sel       (ptr_q),
    .wdata     (host_wdata),
    .halted    (main_rd[B_HALT]),
    .init_addr (init_addr),
    .bus_cfg   (bus_cfg),
    .filt      (filter_bits),
    .mode      (mode_word),
    .rd_val    (cfg_rd)
  );

  assign cmd_load  = cmd.load;
  assign cmd_run   = cmd.run;
  assign cmd_halt  = cmd.halt;
  assign cmd_poll  = cmd.poll;
  assign tx_enable = act;
  assign rx_enable = act;
endmodule

// File: rtl/enet_regport_chk.sv
module enet_regport_chk
  import enet_regport_pkg::*;
#(
  parameter int unsigned PTR_W = 4,
  parameter int unsigned IBA_W = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                host_en,
  input logic                host_we,
  input logic                host_word,
  input logic [WORD_W-1:0]   host_wdata,
  input logic [PTR_W-1:0]    ptr,
  input logic [WORD_W-1:0]   main_val,
  input logic                irq,
  input logic                cmd_halt,
  input logic                cmd_poll,
  input logic                tx_enable,
  input logic [IBA_W-1:0]    init_addr,
  input logic [BUSCFG_W-1:0] bus_cfg
);
  logic main_write;
  assign main_write = host_en && host_we && !host_word && (ptr == '0);

  p_halt_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (main_write && host_wdata[B_HALT]) |=> (main_val == 16'h0004));

  p_halt_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_halt |-> (main_val == 16'h0004));

  p_active_needs_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_enable |-> main_val[B_RUN]);

  p_halted_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (main_val[B_HALT] && !main_write) |=> $stable(main_val));

  p_err_summary_r8: assert property (@(posedge clk) disable iff (!rst_n)
    main_val[B_ERRSUM] == (|main_val[14:11]));

  p_irq_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (main_val[B_IEN] && main_val[B_IRQSUM]));

  p_poll_running_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_poll |-> $past(!main_val[B_HALT]));

  p_cfg_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !main_val[B_HALT] |=> ($stable(init_addr) && $stable(bus_cfg)));
endmodule

bind enet_regport enet_regport_chk #(.PTR_W(PTR_W), .IBA_W(IBA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_en    (host_en),
  .host_we    (host_we),
  .host_word  (host_word),
  .host_wdata (host_wdata),
  .ptr        (ptr_q),
  .main_val   (main_rd),
  .irq        (irq),
  .cmd_halt   (cmd_halt),
  .cmd_poll   (cmd_poll),
  .tx_enable  (tx_enable),
  .init_addr  (init_addr),
  .bus_cfg    (bus_cfg)
);

// File: tb/test_enet_regport.sv
`timescale 1ns/1ps
module test_enet_regport;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_en = 1'b0, host_we = 1'b0, host_word = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        ev_load_done = 0, ev_tx_done = 0, ev_rx_done = 0, ev_mem_err = 0;
  logic        ev_rx_lost = 0, ev_col_chk = 0, ev_jabber = 0;
  logic        cmd_load, cmd_run, cmd_halt, cmd_poll, tx_enable, rx_enable, irq;
  logic [23:0] init_addr;
  logic [2:0]  bus_cfg;
  logic [63:0] filter_bits;
  logic [15:0] mode_word;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  enet_regport i_enet_regport (
    .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_we(host_we),
    .host_word(host_word), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ev_load_done(ev_load_done), .ev_tx_done(ev_tx_done), .ev_rx_done(ev_rx_done),
    .ev_mem_err(ev_mem_err), .ev_rx_lost(ev_rx_lost), .ev_col_chk(ev_col_chk),
    .ev_jabber(ev_jabber), .cmd_load(cmd_load), .cmd_run(cmd_run),
    .cmd_halt(cmd_halt), .cmd_poll(cmd_poll), .tx_enable(tx_enable),
    .rx_enable(rx_enable), .irq(irq), .init_addr(init_addr), .bus_cfg(bus_cfg),
    .filter_bits(filter_bits), .mode_word(mode_word)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic w, input logic [15:0] d);
    @(negedge clk);
    host_en = 1; host_we = 1; host_word = w; host_wdata = d;
    @(negedge clk);
    host_en = 0; host_we = 0; host_word = 0;
  endtask

  task automatic wr_reg(input int n, input logic [15:0] d);
    wr(1'b1, 16'(n));
    wr(1'b0, d);
  endtask

  task automatic rd_reg(input int n, output logic [15:0] v);
    wr(1'b1, 16'(n));
    host_word = 0;
    #1 v = host_rdata;
  endtask

  task automatic ev(input logic [6:0] m);
    @(negedge clk);
    {ev_jabber, ev_col_chk, ev_rx_lost, ev_mem_err, ev_rx_done, ev_tx_done, ev_load_done} = m;
    @(negedge clk);
    {ev_jabber, ev_col_chk, ev_rx_lost, ev_mem_err, ev_rx_done, ev_tx_done, ev_load_done} = '0;
  endtask

  // expected main register while running: load, run and both active bits set
  function automatic logic [15:0] exp_run(input logic [6:0] c, input logic ien);
    logic errs, intr;
    errs = c[6] | c[5] | c[4] | c[3];
    intr = c[6] | c[4] | c[3] | c[2] | c[1] | c[0];
    return {errs, c, intr, ien, 2'b11, 2'b00, 2'b11};
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic        ien;
    logic [6:0]  c, m;

    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1
    chk("R1 main reset", host_rdata, 16'h0004);
    chk("R1 irq/enables/pulses", {irq, tx_enable, rx_enable, cmd_load, cmd_run, cmd_halt, cmd_poll}, 0);

    // R2 pointer and unimplemented registers
    wr(1'b1, 16'h0003);
    host_word = 1; #1;
    chk("R2 pointer readback", host_rdata, 16'h0003);
    host_word = 0;
    wr_reg(5, 16'hFFFF);
    rd_reg(5, v);
    chk("R2 unimplemented reads 0", v, 0);

    // R11 while halted
    wr_reg(1, 16'hBEEF);
    wr_reg(2, 16'hFF12);
    wr_reg(3, 16'hFFFF);
    rd_reg(2, v);
    chk("R11 high address read", v, 16'h0012);
    rd_reg(3, v);
    chk("R11 bus config read", v, 16'h0007);
    chk("R11 init_addr out", init_addr, 24'h12BEEF);

    // R12 filter words
    for (int i = 0; i < 4; i++) wr_reg(8 + i, 16'h1111 * 16'(i + 1));
    chk("R12 filter outputs", filter_bits, 64'h4444_3333_2222_1111);
    rd_reg(9, v);
    chk("R12 filter read", v, 16'h2222);

    // R7 events ignored while halted
    rd_reg(0, v);
    ev(7'h7F);
    #1 chk("R7 halted ignores events", host_rdata, 16'h0004);
    chk("R7 no irq", irq, 0);

    // R10 poll ignored while halted
    wr(1'b0, 16'h0008);
    chk("R10 no poll while halted", cmd_poll, 0);
    #1 chk("R10 halted unchanged", host_rdata, 16'h0004);

    // R4 load
    wr(1'b0, 16'h0001);
    chk("R4 load pulse", cmd_load, 1);
    #1 chk("R4 load readback", host_rdata, 16'h0001);
    @(negedge clk);
    chk("R4 load pulse single", cmd_load, 0);
    ev(7'h01);
    #1 chk("R4 load done sets bit 8", host_rdata, 16'h0181);

    // R11 locked while not halted
    wr_reg(1, 16'h1234);
    wr_reg(3, 16'h0000);
    chk("R11 address locked", init_addr, 24'h12BEEF);
    chk("R11 bus config locked", bus_cfg, 3'h7);

    // R5 run
    wr_reg(0, 16'h0142);
    chk("R5 run pulse", cmd_run, 1);
    #1 chk("R5 run before active", host_rdata, 16'h0043);
    @(negedge clk);
    #1 chk("R5 active set", host_rdata, 16'h0073);
    chk("R5 enables", {tx_enable, rx_enable}, 2'b11);
    wr(1'b0, 16'h0040);
    #1 chk("R5 bits 0/1/4/5 unaffected by zero/one writes", host_rdata, 16'h0073);
    wr(1'b0, 16'h80C0);
    #1 chk("R8 summary bits not writable", host_rdata, 16'h0073);

    // R10 poll while running
    wr(1'b0, 16'h0048);
    chk("R10 poll pulse", cmd_poll, 1);
    #1 chk("R10 bit 3 reads 0", host_rdata, 16'h0073);
    @(negedge clk);
    chk("R10 poll pulse single", cmd_poll, 0);

    // R12 mode at any time
    wr_reg(15, 16'h8000);
    chk("R12 mode written while running", mode_word, 16'h8000);
    wr(1'b1, 16'h0000);

    // R6 R8 R9 sweep over all cause patterns
    ien = 1'b1;
    for (int p = 0; p < 128; p++) begin
      c = 7'(p);
      ev(c);
      #1 chk("R8 summaries after events", host_rdata, exp_run(c, ien));
      chk("R9 irq", irq, (|{c[6], c[4:0]}) & ien);
      m = 7'((p * 5 + 3) & 127);
      ien = 1'(p >> 1);
      wr(1'b0, {1'b0, m, 1'b0, ien, 6'b0});
      c = c & ~m;
      #1 chk("R6 one-to-clear", host_rdata, exp_run(c, ien));
      chk("R9 irq after clear", irq, (|{c[6], c[4:0]}) & ien);
      wr(1'b0, {1'b0, 7'h7F, 1'b0, ien, 6'b0});
      #1 chk("R6 clear all", host_rdata, exp_run(7'h00, ien));
    end

    // R6 event beats clear in the same cycle
    @(negedge clk);
    ev_tx_done = 1; host_en = 1; host_we = 1; host_word = 0; host_wdata = 16'h0240;
    @(negedge clk);
    ev_tx_done = 0; host_en = 0; host_we = 0;
    #1 chk("R6 event wins over clear", host_rdata, 16'h02F3);
    chk("R9 irq with enable", irq, 1);

    // R3 halt dominance with load in same write
    ev(7'h7F);
    wr(1'b0, 16'h0005);
    chk("R3 halt pulse", cmd_halt, 1);
    chk("R3 no load pulse", cmd_load, 0);
    #1 chk("R3 reads exactly halt", host_rdata, 16'h0004);
    chk("R3 enables and irq cleared", {tx_enable, rx_enable, irq}, 3'b000);
    @(negedge clk);
    chk("R3 halt pulse single", cmd_halt, 0);
    wr_reg(1, 16'h5555);
    chk("R11 writable again after halt", init_addr, 24'h125555);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule